// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small processor core and tells the core, at each instruction boundary, whether to divert and where to go. One source is a non-maskable urgent line. Three are vectored levels (L3 highest, then L2, then L1) that each redirect the core to a fixed address of their own. The lowest source is an external request that supplies no vector; external logic instead provides the next instruction during an acknowledge strobe.

The core pulses `sample_i` on the next-to-last clock of every instruction. Only at that edge does the block pick a winner. It registers the decision and presents it for exactly one cycle on `take_o`, `src_o` and `vector_o`. The block also holds a global enable, which software sets and clears through command strobes, and a three-bit mask for the vectored levels. Both reach the core through plain control pins. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `ien_o` is 0, `mask_o` is 3'b111 (all levels blocked), and `take_o`, `src_o`, `vector_o`, `pc_hold_o` and `ack_o` are all 0.
- R2: A decision is made only at a rising clock edge where `sample_i` is 1. `take_o` is then 1 for exactly the next cycle, and it is 0 in every other cycle.
- R3: When several sources are eligible, the winner follows the fixed order urgent > L3 > L2 > L1 > external. `src_o` is one-hot, with bit 4 = urgent, bit 3 = L3, bit 2 = L2, bit 1 = L1 and bit 0 = external.
- R4: The urgent line is eligible whatever the enable and mask hold. It arms on a rising edge and must still be high at the sampling edge. Each high pulse yields at most one acceptance, and a pulse that falls before sampling yields none.
- R5: `ien_set_i` sets the enable and `ien_clr_i` clears it, with the clear winning if both are asserted. Every acceptance clears the enable, and this takes priority over a set command in the same cycle.
- R6: `mask_wr_i` loads `mask_data_i` into the mask, where bit 0 is L1, bit 1 is L2 and bit 2 is L3, and 1 means blocked. A blocked level or a cleared enable makes L3, L2, L1 and external ineligible.
- R7: `vector_o` during `take_o` is 0x0024 for urgent, 0x002C for L1, 0x0034 for L2, 0x003C for L3, and 0 for external.
- R8: L3 is edge-captured. A rising edge is remembered even if the line falls before sampling, and even while L3 is masked. The memory is cleared only when L3 is accepted.
- R9: L2, L1 and external are level-sensitive. They count only if high at the sampling edge.
- R10: When external wins, `pc_hold_o` is 1 in the `take_o` cycle. `ack_o` is high for exactly ACK_LEN consecutive cycles starting in that same cycle, and it is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_nmi_i | input | 1 | Non-maskable urgent line |
| irq_l3_i | input | 1 | Highest vectored level, edge-captured |
| irq_l2_i | input | 1 | Middle vectored level, level-sensitive |
| irq_l1_i | input | 1 | Lowest vectored level, level-sensitive |
| irq_ext_i | input | 1 | External request without vector |
| sample_i | input | 1 | Next-to-last clock of the instruction |
| ien_set_i | input | 1 | Enable command |
| ien_clr_i | input | 1 | Disable command |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 3 | New mask, 1 = blocked |
| take_o | output | 1 | Divert at this instruction boundary |
| src_o | output | 5 | One-hot winning source |
| vector_o | output | VEC_W | Target address for the winner |
| pc_hold_o | output | 1 | Hold the program counter (external winner) |
| ack_o | output | 1 | Acknowledge strobe with read timing |
| ien_o | output | 1 | Global enable state |
| mask_o | output | 3 | Current mask |

## Verification
The bench builds the block with ACK_LEN = 3 and the default vector base and step. A three-cycle acknowledge shows the length of the strobe, not just whether it is present. Five request lines, both enable states and all eight mask values give 512 combinations, and the bench sweeps all of them. It computes the winner, vector and enable outcome for each one arithmetically. Directed sequences then cover the behaviour that depends on time: urgent pulses that are held, repeated or dropped; an L3 edge that is latched while masked; the set/clear conflict; and the absence of any decision without a sampling strobe.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N   = 5;
  localparam int SRC_EXT = 0;
  localparam int SRC_L1  = 1;
  localparam int SRC_L2  = 2;
  localparam int SRC_L3  = 3;
  localparam int SRC_NMI = 4;
  localparam int LVL_N   = 3;

  typedef enum logic {
    LATCH_HELD,   // armed by an edge, dropped when the line falls
    LATCH_STICKY  // armed by an edge, kept until serviced
  } latch_mode_e;
endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch
  import irqc_pkg::*;
#(
  parameter latch_mode_e MODE = LATCH_STICKY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clear_i,
  output logic req_o
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise = line_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_i;
  end

  generate
    if (MODE == LATCH_HELD) begin : g_held
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (rise)               pend_q <= 1'b1;
        else if (!line_i || clear_i) pend_q <= 1'b0;
      end
      assign req_o = pend_q & line_i;

      // R4: an armed urgent request implies the line was high at the last edge
      assert_held_tracks_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> $past(line_i));
    end else begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (rise)    pend_q <= 1'b1;
        else if (clear_i) pend_q <= 1'b0;
      end
      assign req_o = pend_q;

      // R8: the memory is only set by a high line
      assert_sticky_set_by_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(line_i));
      // R8: once set, it stays until serviced
      assert_sticky_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q) && !$past(clear_i)) |-> pend_q);
    end
  endgenerate
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] win_o,
  output logic         any_o
);
  logic [N:0] above;

  assign above[N] = 1'b0;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_lvl
      assign win_o[gi] = req_i[gi] & ~above[gi+1];
      assign above[gi] = above[gi+1] | req_i[gi];
    end
  endgenerate

  assign any_o = above[0];

  always_comb begin
    // R3: never more than one winner, and a winner whenever anything asks
    assert_single_winner_R3: assert ($countones(win_o) <= 1);
    assert_winner_if_any_R3: assert (any_o == (win_o != '0));
  end
endmodule

// File: rtl/irqc_ack_pulse.sv
module irqc_ack_pulse #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ack_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ack_o = (cnt_q != '0);

  // R10: a start always produces the strobe in the next cycle
  assert_ack_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ack_o);
  // R10: the strobe never appears out of nowhere
  assert_ack_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(start_i));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 36,
  parameter int VEC_STEP = 8,
  parameter int ACK_LEN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_nmi_i,
  input  logic             irq_l3_i,
  input  logic             irq_l2_i,
  input  logic             irq_l1_i,
  input  logic             irq_ext_i,
  input  logic             sample_i,
  input  logic             ien_set_i,
  input  logic             ien_clr_i,
  input  logic             mask_wr_i,
  input  logic [2:0]       mask_data_i,
  output logic             take_o,
  output logic [4:0]       src_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             pc_hold_o,
  output logic             ack_o,
  output logic             ien_o,
  output logic [2:0]       mask_o
);
  logic [LVL_N-1:0] mask_q;
  logic             ien_q;
  logic             nmi_req;
  logic             l3_req;
  logic [SRC_N-1:0] req;
  logic [SRC_N-1:0] win;
  logic             any_req;
  logic             accept;
  logic [VEC_W-1:0] vec_tab [SRC_N];
  logic [VEC_W-1:0] vec_next;
  logic             take_q;
  logic [SRC_N-1:0] src_q;
  logic [VEC_W-1:0] vec_q;
  logic             hold_q;

  assign accept = sample_i & any_req;

  irqc_edge_latch #(.MODE(LATCH_HELD)) u_nmi_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (irq_nmi_i),
    .clear_i (sample_i & win[SRC_NMI]),
    .req_o   (nmi_req)
  );

  irqc_edge_latch #(.MODE(LATCH_STICKY)) u_l3_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (irq_l3_i),
    .clear_i (sample_i & win[SRC_L3]),
    .req_o   (l3_req)
  );

  assign req[SRC_NMI] = nmi_req;
  assign req[SRC_L3]  = ien_q & ~mask_q[2] & l3_req;
  assign req[SRC_L2]  = ien_q & ~mask_q[1] & irq_l2_i;
  assign req[SRC_L1]  = ien_q & ~mask_q[0] & irq_l1_i;
  assign req[SRC_EXT] = ien_q & irq_ext_i;

  irqc_prio_pick #(.N(SRC_N)) u_pick (
    .req_i (req),
    .win_o (win),
    .any_o (any_req)
  );

  generate
    for (genvar gv = 0; gv < SRC_N; gv++) begin : g_vec
      if (gv == SRC_EXT) begin : g_none
        assign vec_tab[gv] = '0;
      end else if (gv == SRC_NMI) begin : g_nmi
        assign vec_tab[gv] = VEC_W'(VEC_BASE);
      end else begin : g_lvl
        assign vec_tab[gv] = VEC_W'(VEC_BASE + VEC_STEP * gv);
      end
    end
  endgenerate

  always_comb begin
    vec_next = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (win[i]) vec_next = vec_next | vec_tab[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (mask_wr_i) mask_q <= mask_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ien_q <= 1'b0;
    else if (accept)    ien_q <= 1'b0;
    else if (ien_clr_i) ien_q <= 1'b0;
    else if (ien_set_i) ien_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= '0;
      vec_q  <= '0;
      hold_q <= 1'b0;
    end else if (accept) begin
      take_q <= 1'b1;
      src_q  <= win;
      vec_q  <= vec_next;
      hold_q <= win[SRC_EXT];
    end else begin
      take_q <= 1'b0;
      src_q  <= '0;
      vec_q  <= '0;
      hold_q <= 1'b0;
    end
  end

  irqc_ack_pulse #(.LEN(ACK_LEN)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept & win[SRC_EXT]),
    .ack_o   (ack_o)
  );

  assign take_o    = take_q;
  assign src_o     = src_q;
  assign vector_o  = vec_q;
  assign pc_hold_o = hold_q;
  assign ien_o     = ien_q;
  assign mask_o    = mask_q;

  // R2: a decision only follows a sampling edge
  assert_take_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));
  // R2: a take never lasts two cycles
  assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o || $past(sample_i, 1));
  // R3: a take carries exactly one source
  assert_src_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $countones(src_o) == 1);
  // R5: acceptance leaves the enable cleared
  assert_ien_drop_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ien_o);
  // R4: the urgent line was high when it was accepted
  assert_nmi_needs_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o[4]) |-> $past(irq_nmi_i));
  // R6: a blocked L2 is never taken
  assert_masked_l2_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o[2]) |-> $past(!mask_o[1] && ien_o));
  // R10: holding the counter only with an external take and its strobe
  assert_ext_holds_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold_o |-> (take_o && src_o[0] && ack_o));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int ACK_LEN = 3;
  localparam int VBASE   = 36;
  localparam int VSTEP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 0, l3 = 0, l2 = 0, l1 = 0, ext = 0;
  logic sample = 0, ien_set = 0, ien_clr = 0, mask_wr = 0;
  logic [2:0] mask_data = '0;
  logic take, pc_hold, ack, ien;
  logic [4:0] src;
  logic [15:0] vector;
  logic [2:0] mask;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.VEC_W(16), .VEC_BASE(VBASE), .VEC_STEP(VSTEP), .ACK_LEN(ACK_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_nmi_i(nmi), .irq_l3_i(l3), .irq_l2_i(l2),
    .irq_l1_i(l1), .irq_ext_i(ext), .sample_i(sample), .ien_set_i(ien_set),
    .ien_clr_i(ien_clr), .mask_wr_i(mask_wr), .mask_data_i(mask_data),
    .take_o(take), .src_o(src), .vector_o(vector), .pc_hold_o(pc_hold),
    .ack_o(ack), .ien_o(ien), .mask_o(mask)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; nmi = 0; l3 = 0; l2 = 0; l1 = 0; ext = 0;
    sample = 0; ien_set = 0; ien_clr = 0; mask_wr = 0; mask_data = '0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_wr = 1; mask_data = m; step(); mask_wr = 0;
  endtask

  task automatic enable();
    ien_set = 1; step(); ien_set = 0;
  endtask

  task automatic strobe();
    sample = 1; step(); sample = 0;
  endtask

  function automatic int vec_for(input int w);
    if (w == 0) return 0;
    if (w == 4) return VBASE;
    return VBASE + VSTEP * w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(ien == 0, "R1", "ien", ien, 0);
    chk(mask == 3'b111, "R1", "mask", mask, 7);
    chk(take == 0 && src == 0 && vector == 0, "R1", "take/src/vec", {take, src}, 0);
    chk(pc_hold == 0 && ack == 0, "R1", "hold/ack", {pc_hold, ack}, 0);

    // sweep: all line patterns x enable x mask (R3 R4 R5 R6 R7 R9 R10)
    for (int pat = 0; pat < 32; pat++) begin
      for (int en = 0; en < 2; en++) begin
        for (int m = 0; m < 8; m++) begin
          int elig, w, acks;
          do_reset();
          write_mask(3'(m));
          if (en == 1) enable();
          nmi = pat[4]; l3 = pat[3]; l2 = pat[2]; l1 = pat[1]; ext = pat[0];
          step();
          l3 = 0;
          step();
          elig = 0;
          elig[4] = pat[4];
          elig[3] = pat[3] & en & ~m[2];
          elig[2] = pat[2] & en & ~m[1];
          elig[1] = pat[1] & en & ~m[0];
          elig[0] = pat[0] & en;
          w = -1;
          for (int k = 0; k < 5; k++) if (elig[k]) w = k;
          strobe();
          chk(take == (w >= 0), "R3", "take", take, w >= 0);
          chk(int'(src) == ((w >= 0) ? (1 << w) : 0), "R3", "src", src, (w >= 0) ? (1 << w) : 0);
          chk(int'(vector) == ((w >= 0) ? vec_for(w) : 0), "R7", "vector", vector,
              (w >= 0) ? vec_for(w) : 0);
          chk(pc_hold == (w == 0), "R10", "pc_hold", pc_hold, w == 0);
          chk(ien == (en == 1 && w < 0), "R5", "ien after", ien, en == 1 && w < 0);
          acks = ack ? 1 : 0;
          for (int k = 0; k < ACK_LEN + 2; k++) begin
            step();
            if (ack) acks++;
          end
          chk(acks == ((w == 0) ? ACK_LEN : 0), "R10", "ack cycles", acks, (w == 0) ? ACK_LEN : 0);
        end
      end
    end

    // R2: no decision without a sampling strobe
    begin
      int seen = 0;
      do_reset(); write_mask(3'b000); enable();
      l2 = 1;
      for (int k = 0; k < 6; k++) begin step(); if (take) seen++; end
      chk(seen == 0, "R2", "take without sample", seen, 0);
      strobe();
      chk(take && src == 5'b00100, "R9", "L2 level taken", src, 4);
      step();
      chk(take == 0, "R2", "take one cycle", take, 0);
      l2 = 0; enable(); step();
      strobe();
      chk(take == 0, "R9", "L2 low not taken", take, 0);
    end

    // R4: held urgent pulse gives one acceptance; dropped pulse none
    do_reset();
    nmi = 1; step(); step();
    strobe();
    chk(take && vector == 16'h0024, "R4", "urgent taken", vector, 36);
    step(); strobe();
    chk(take == 0, "R4", "urgent once per pulse", take, 0);
    nmi = 0; step(); nmi = 1; step(); nmi = 0; step();
    strobe();
    chk(take == 0, "R4", "dropped pulse", take, 0);

    // R8: L3 edge kept while masked, cleared when serviced
    do_reset(); enable();
    l3 = 1; step(); l3 = 0; step();
    strobe();
    chk(take == 0, "R8", "masked L3", take, 0);
    write_mask(3'b000);
    strobe();
    chk(take && src == 5'b01000 && vector == 16'h003C, "R8", "latched L3", vector, 60);
    enable(); step();
    strobe();
    chk(take == 0, "R8", "latch cleared", take, 0);

    // R5: clear wins over set; plain set and clear
    do_reset();
    ien_set = 1; ien_clr = 1; step(); ien_set = 0; ien_clr = 0;
    chk(ien == 0, "R5", "set+clr", ien, 0);
    enable();
    chk(ien == 1, "R5", "set", ien, 1);
    ien_clr = 1; step(); ien_clr = 0;
    chk(ien == 0, "R5", "clr", ien, 0);
    // R5: acceptance beats a simultaneous set
    write_mask(3'b000); enable(); l1 = 1; step();
    sample = 1; ien_set = 1; step(); sample = 0; ien_set = 0;
    chk(take && ien == 0, "R5", "accept over set", ien, 0);
    l1 = 0;

    // R6: mask load
    write_mask(3'b101);
    chk(mask == 3'b101, "R6", "mask load", mask, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule